// File: doc/BRIEF.md
# Timer Event Flag Register Block

This block keeps the pending-event flags of an eight-channel timer behind a byte-wide register bus. One byte holds a flag for each input-capture/output-compare channel. A second byte carries the counter-overflow flag in its top bit. The block sets a flag when the matching event strobe from the timer core arrives. Software clears flags by writing ones to them. A write-one clear is honoured only while the timer or the pulse accumulator is enabled.

A fast-clear mode lets software skip the explicit write. While this mode is on, reading a channel's capture register or writing its compare register clears that channel's flag. Each flag drives its own interrupt request, masked by an enable bit, and an OR of all requests gives a single combined line. The counter, the capture and compare data paths, the prescaler and the pulse accumulator lie outside this block; their strobes and enables arrive as inputs.

The register bus has no back-pressure. A read or write strobe lasts one cycle, and the block accepts every access at once, so no valid/ready pair is needed. Control, event and interrupt pins are plain levels or strobes.

Top module: `tim_flag_regs`

## Requirements
- R1: A read at address 0x0E returns the channel flag byte, with bit n holding channel n. A read at 0x0F returns the overflow byte. A read at any other address returns zero.
- R2: A high `chan_evt[n]` at a clock edge sets channel flag n from that edge on. A high `ovf_evt` sets the overflow flag in the same way.
- R3: The overflow flag is bit 7 of the byte at 0x0F. Bits 6:0 of that byte always read as zero.
- R4: A write with a one in bit n clears that flag (0x0E: channel n; 0x0F: bit 7 is the overflow flag). A zero bit leaves its flag unchanged.
- R5: A write-one clear takes effect only while `tmr_en` or `pacc_en` is high. With both low, the write changes no flag.
- R6: While `fast_clr_en` is high, a read or a write at address 0x10+2n clears channel flag n. The odd address 0x11+2n clears nothing. With `fast_clr_en` low, accesses in 0x10–0x1F clear nothing. The module enables do not gate a fast clear.
- R7: Channels at or above `NUM_CH` read as zero, ignore their event strobes, and ignore writes.
- R8: After reset, every flag is zero and every interrupt output is low.
- R9: If a set event and a clear (write-one or fast) hit the same flag in the same cycle, the flag ends up set.
- R10: `chan_irq[n]` equals channel flag n AND `chan_ie[n]`. `ovf_irq` equals the overflow flag AND `ovf_ie`. `irq_any` is the OR of all of these.
- R11: `bus_rdata` is combinational: it reflects the addressed byte in the same cycle as the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| chan_evt | input | 8 | Capture/compare event strobes, one per channel |
| ovf_evt | input | 1 | Counter overflow strobe |
| tmr_en | input | 1 | Timer enable level |
| pacc_en | input | 1 | Pulse-accumulator enable level |
| fast_clr_en | input | 1 | Fast-clear mode select |
| chan_ie | input | 8 | Channel interrupt enables |
| ovf_ie | input | 1 | Overflow interrupt enable |
| chan_irq | output | 8 | Per-channel interrupt requests |
| ovf_irq | output | 1 | Overflow interrupt request |
| irq_any | output | 1 | OR of all interrupt requests |

## Verification
Flag changes caused by events, write-one clears and fast clears appear one clock edge after the strobe. Read data and interrupt outputs follow the current flags in the same cycle, with no register in between. The bench drives each stimulus on a falling edge and checks read data and interrupt outputs 1 ns later, against the model state from before the coming rising edge. It then moves the model to its next state at that rising edge, so every result is compared in the cycle in which it is due.

// File: rtl/tfr_pkg.sv
package tfr_pkg;
  localparam int MAX_CH      = 8;
  localparam int BYTE_W      = 8;
  localparam int OFS_CH_FLG  = 14;
  localparam int OFS_OVF_FLG = 15;
  localparam int OFS_DATA    = 16;
  localparam int DATA_BYTES  = 2;
endpackage

// File: rtl/tfr_decode.sv
module tfr_decode
  import tfr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NUM_CH = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              clr_allow,
  input  logic              fast_en,
  output logic [MAX_CH-1:0] ch_clr,
  output logic              ovf_clr,
  output logic              sel_ch,
  output logic              sel_ovf
);
  localparam logic [ADDR_W-1:0] A_CH  = ADDR_W'(OFS_CH_FLG);
  localparam logic [ADDR_W-1:0] A_OVF = ADDR_W'(OFS_OVF_FLG);

  logic [MAX_CH-1:0] fast_hit;
  logic              wr_ch;

  assign sel_ch  = (addr == A_CH);
  assign sel_ovf = (addr == A_OVF);
  assign wr_ch   = wr && sel_ch && clr_allow;
  assign ovf_clr = wr && sel_ovf && clr_allow && wdata[BYTE_W-1];

  for (genvar n = 0; n < MAX_CH; n++) begin : g_fast
    if (n < NUM_CH) begin : g_on
      localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(OFS_DATA + DATA_BYTES * n);
      assign fast_hit[n] = fast_en && (rd || wr) && (addr == A_HI);
    end else begin : g_off
      assign fast_hit[n] = 1'b0;
    end
  end

  assign ch_clr = ({MAX_CH{wr_ch}} & wdata[MAX_CH-1:0]) | fast_hit;
endmodule

// File: rtl/tfr_flag_bank.sv
module tfr_flag_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_o[i] <= 1'b0;
      else if (set_i[i])   flag_o[i] <= 1'b1;
      else if (clr_i[i])   flag_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/tfr_irq.sv
module tfr_irq #(
  parameter int W = 9
) (
  input  logic [W-1:0] flag,
  input  logic [W-1:0] ie,
  output logic [W-1:0] req,
  output logic         any
);
  assign req = flag & ie;
  assign any = |req;
endmodule

// File: rtl/tim_flag_regs.sv
module tim_flag_regs
  import tfr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        chan_evt,
  input  logic              ovf_evt,
  input  logic              tmr_en,
  input  logic              pacc_en,
  input  logic              fast_clr_en,
  input  logic [7:0]        chan_ie,
  input  logic              ovf_ie,
  output logic [7:0]        chan_irq,
  output logic              ovf_irq,
  output logic              irq_any
);
  localparam int IRQ_W = MAX_CH + 1;

  logic [MAX_CH-1:0] ch_clr;
  logic              ovf_clr;
  logic              sel_ch, sel_ovf;
  logic [MAX_CH-1:0] chan_q;
  logic              ovf_q;
  logic [IRQ_W-1:0]  req;

  tfr_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .wdata(bus_wdata),
    .clr_allow(tmr_en | pacc_en), .fast_en(fast_clr_en),
    .ch_clr(ch_clr), .ovf_clr(ovf_clr), .sel_ch(sel_ch), .sel_ovf(sel_ovf)
  );

  tfr_flag_bank #(.W(NUM_CH)) u_ch_bank (
    .clk(clk), .rst_n(rst_n),
    .set_i(chan_evt[NUM_CH-1:0]), .clr_i(ch_clr[NUM_CH-1:0]),
    .flag_o(chan_q[NUM_CH-1:0])
  );

  if (NUM_CH < MAX_CH) begin : g_pad
    assign chan_q[MAX_CH-1:NUM_CH] = '0;
  end

  tfr_flag_bank #(.W(1)) u_ovf_bank (
    .clk(clk), .rst_n(rst_n),
    .set_i(ovf_evt), .clr_i(ovf_clr), .flag_o(ovf_q)
  );

  tfr_irq #(.W(IRQ_W)) u_irq (
    .flag({ovf_q, chan_q}), .ie({ovf_ie, chan_ie}),
    .req(req), .any(irq_any)
  );

  assign chan_irq = req[MAX_CH-1:0];
  assign ovf_irq  = req[MAX_CH];

  always_comb begin
    if (sel_ch)       bus_rdata = chan_q;
    else if (sel_ovf) bus_rdata = {ovf_q, 7'b0};
    else              bus_rdata = '0;
  end
endmodule

// File: rtl/tfr_chk.sv
module tfr_chk #(
  parameter int ADDR_W = 6,
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rdata,
  input logic [7:0]        chan_evt,
  input logic              ovf_evt,
  input logic              tmr_en,
  input logic              pacc_en,
  input logic              fast_clr_en,
  input logic [7:0]        chan_ie,
  input logic [7:0]        chan_irq,
  input logic [7:0]        chan_q,
  input logic              ovf_q
);
  localparam logic [7:0] IMPL = 8'((9'd1 << NUM_CH) - 9'd1);

  // R2 and R9: an implemented event always leaves its flag set, whatever clear arrives with it
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((chan_evt & IMPL) != 8'h00) |=> ((chan_q & $past(chan_evt & IMPL)) == $past(chan_evt & IMPL)));

  assert_ovf_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_q);

  // R5: with both enables low and fast clear off, no flag can fall
  assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_en && !pacc_en && !fast_clr_en) |=>
      (((chan_q & $past(chan_q)) == $past(chan_q)) && (ovf_q || !$past(ovf_q))));

  // R3: low bits of the overflow byte read zero
  assert_ovf_low_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(15)) |-> (bus_rdata[6:0] == 7'd0));

  // R7: unimplemented channel bits read zero
  assert_unimpl_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(14)) |-> ((bus_rdata & ~IMPL) == 8'h00));

  // R10: no channel request without its enable
  assert_irq_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((chan_irq & ~chan_ie) == 8'h00));
endmodule

bind tim_flag_regs tfr_chk #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .chan_evt(chan_evt), .ovf_evt(ovf_evt), .tmr_en(tmr_en), .pacc_en(pacc_en),
  .fast_clr_en(fast_clr_en), .chan_ie(chan_ie), .chan_irq(chan_irq),
  .chan_q(chan_q), .ovf_q(ovf_q)
);

// File: tb/tb_tim_flag_regs.sv
module tb_tim_flag_regs;
  localparam int AW = 6;
  localparam int NCH = 6;
  localparam logic [7:0] IMPL = 8'h3F;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [7:0]    chan_evt = '0;
  logic          ovf_evt = 1'b0;
  logic          tmr_en = 1'b0, pacc_en = 1'b0, fast_clr_en = 1'b0;
  logic [7:0]    chan_ie = '0;
  logic          ovf_ie = 1'b0;
  logic [7:0]    chan_irq;
  logic          ovf_irq, irq_any;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_ch = '0;
  logic       m_ov = 1'b0;
  logic [7:0] last_rd;

  always #10 clk = ~clk;

  tim_flag_regs #(.ADDR_W(AW), .NUM_CH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chan_evt(chan_evt), .ovf_evt(ovf_evt),
    .tmr_en(tmr_en), .pacc_en(pacc_en), .fast_clr_en(fast_clr_en), .chan_ie(chan_ie),
    .ovf_ie(ovf_ie), .chan_irq(chan_irq), .ovf_irq(ovf_irq), .irq_any(irq_any)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [7:0] nxt_ch(logic [7:0] cur);
    logic [7:0] clr = '0;
    if (bus_wr && bus_addr == AW'(14) && (tmr_en || pacc_en)) clr = bus_wdata;
    if (fast_clr_en && (bus_wr || bus_rd) && bus_addr >= AW'(16) && bus_addr <= AW'(31)
        && !bus_addr[0])
      clr[(int'(bus_addr) - 16) / 2] = 1'b1;
    return ((cur & ~clr) | chan_evt) & IMPL;
  endfunction

  function automatic logic nxt_ov(logic cur);
    logic c = bus_wr && bus_addr == AW'(15) && (tmr_en || pacc_en) && bus_wdata[7];
    return (cur && !c) || ovf_evt;
  endfunction

  function automatic logic [7:0] exp_rd();
    if (bus_addr == AW'(14)) return m_ch;
    if (bus_addr == AW'(15)) return {m_ov, 7'b0};
    return 8'h00;
  endfunction

  // inputs are already set by the caller before the falling edge window closes
  task automatic cycle();
    logic [7:0] nc;
    logic       no;
    #1;
    chk("R10", {6'b0, irq_any, ovf_irq, chan_irq},
        {6'b0, |({m_ov, m_ch} & {ovf_ie, chan_ie}), m_ov & ovf_ie, m_ch & chan_ie});
    if (bus_rd) begin
      last_rd = bus_rdata;
      chk("R1_R11", {8'b0, bus_rdata}, {8'b0, exp_rd()});
    end
    nc = nxt_ch(m_ch);
    no = nxt_ov(m_ov);
    @(posedge clk);
    m_ch = nc;
    m_ov = no;
    @(negedge clk);
    bus_rd = 0; bus_wr = 0; chan_evt = '0; ovf_evt = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    bus_addr = a; bus_rd = 1; cycle();
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1; cycle();
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8: reset state
    chk("R8", {15'b0, irq_any}, 16'h0000);
    chan_ie = 8'hFF; ovf_ie = 1;
    rd(AW'(14)); chk("R8", {8'b0, last_rd}, 16'h0000);
    rd(AW'(15)); chk("R8", {8'b0, last_rd}, 16'h0000);
    // R2: events set flags
    chan_evt = 8'h21; cycle();
    rd(AW'(14)); chk("R2", {8'b0, last_rd}, 16'h0021);
    // R7: unimplemented channels ignore events and writes
    chan_evt = 8'hC0; cycle();
    tmr_en = 1; wr(AW'(14), 8'hC0);
    rd(AW'(14)); chk("R7", {8'b0, last_rd}, 16'h0021);
    // R5: clear ignored with both enables low
    tmr_en = 0; wr(AW'(14), 8'hFF);
    rd(AW'(14)); chk("R5", {8'b0, last_rd}, 16'h0021);
    // R4: one clears, zero keeps (pulse-accumulator enable alone suffices, R5)
    pacc_en = 1; wr(AW'(14), 8'h01);
    rd(AW'(14)); chk("R4", {8'b0, last_rd}, 16'h0020);
    // R3: overflow flag sits in bit 7
    ovf_evt = 1; cycle();
    rd(AW'(15)); chk("R3", {8'b0, last_rd}, 16'h0080);
    // R9: set beats clear in the same cycle
    ovf_evt = 1; wr(AW'(15), 8'h80);
    rd(AW'(15)); chk("R9", {8'b0, last_rd}, 16'h0080);
    wr(AW'(15), 8'h80);
    rd(AW'(15)); chk("R4", {8'b0, last_rd}, 16'h0000);
    // R6: fast clear, not gated by enables; odd byte does nothing
    pacc_en = 0; fast_clr_en = 1;
    rd(AW'(27));
    rd(AW'(14)); chk("R6", {8'b0, last_rd}, 16'h0020);
    rd(AW'(26));
    rd(AW'(14)); chk("R6", {8'b0, last_rd}, 16'h0000);
    chan_evt = 8'h01; cycle();
    fast_clr_en = 0; wr(AW'(16), 8'h55);
    rd(AW'(14)); chk("R6", {8'b0, last_rd}, 16'h0001);
    fast_clr_en = 1; wr(AW'(16), 8'h55);
    rd(AW'(14)); chk("R6", {8'b0, last_rd}, 16'h0000);
    // R10: masked interrupt
    chan_evt = 8'h04; chan_ie = 8'h04; ovf_ie = 0; cycle();
    #1; chk("R10", {6'b0, irq_any, ovf_irq, chan_irq}, 16'h0204);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int op = $urandom_range(0, 2);
      int as = $urandom_range(0, 3);
      tmr_en      = ($urandom_range(0, 3) != 0);
      pacc_en     = ($urandom_range(0, 3) == 0);
      fast_clr_en = $urandom_range(0, 1) == 1;
      chan_ie     = 8'($urandom);
      ovf_ie      = $urandom_range(0, 1) == 1;
      for (int b = 0; b < 8; b++) chan_evt[b] = ($urandom_range(0, 7) == 0);
      ovf_evt     = ($urandom_range(0, 7) == 0);
      bus_wdata   = 8'($urandom);
      case (as)
        0: bus_addr = AW'(14);
        1: bus_addr = AW'(15);
        2: bus_addr = AW'(16 + $urandom_range(0, 15));
        default: bus_addr = AW'($urandom);
      endcase
      bus_rd = (op == 1);
      bus_wr = (op == 2);
      cycle();
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule